// File: doc/BRIEF.md
# Eight-Bit Accumulator Core

A small multi-cycle processor with one 8-bit accumulator and no register file, cache, pipeline or branch prediction. It reads two-byte instructions from a byte-wide memory through one synchronous port. The port has one cycle of read latency. Each instruction runs through five phases: two fetch phases, a decode phase, an operand phase and an execute phase. The core supports eight operations. Four change data (bitwise AND, invert, add, shift), two move data (load, store), one compares and one branches. The branch is relative and also acts as the no-operation and as the stop instruction.

The core keeps two condition flags, negative and positive. A conditional branch tests them. Wider operations such as OR and subtraction are built from the primitives in software. After reset the core starts at address zero. It runs until it meets the stop encoding and then freezes, with `halted` high.

Top module: `acc8_core`

## Requirements
- R1: After a reset cycle `halted` is 0, `mem_we` is 0 and `mem_addr` is 0, because the program counter starts at zero. A reset also clears a halted core.
- R2: Instruction byte 0 holds the opcode in bits 7:5: 0 AND, 1 NOT, 2 ADD, 3 SHFT, 4 LD, 5 ST, 6 CMP, 7 JMP. Bits 4:0 hold control bits. Byte 1 holds the address or the amount. Each instruction takes exactly 5 clock cycles. Its bytes are fetched from PC and PC+1, and the PC advances by 2.
- R3: AND sets the accumulator to the accumulator ANDed with the byte at the address in byte 1. NOT inverts every bit of the accumulator.
- R4: ADD adds the addressed byte to the accumulator, modulo 256. LD copies the addressed byte into the accumulator.
- R5: ST writes the accumulator to the address in byte 1. `mem_we` is high for exactly one cycle, during the operand phase of ST only, and no other location changes.
- R6: SHFT shifts the accumulator by byte1 bits 2:0; the upper bits of byte 1 are ignored. Control bit 4 set means left. Control bit 3 set means arithmetic: a right shift then fills with the sign bit. A left shift always fills with zeros.
- R7: After AND, NOT, ADD, SHFT or LD, the flags take the result's sign: N=1 for negative, P=1 for positive and non-zero, and both are 0 for zero.
- R8: CMP compares the accumulator with the addressed byte as signed numbers. It sets P if the accumulator is greater and N if it is smaller, and clears both if they are equal. The accumulator is unchanged.
- R9: JMP control bits are: bit 3 backward, bit 2 take-if-N, bit 1 take-if-P, bit 0 always. When taken, the next PC is PC+2 plus or minus twice byte 1. Otherwise it is PC+2. ST and JMP leave the flags unchanged.
- R10: A JMP with amount zero behaves as a no-operation.
- R11: Bytes 0xFF 0xFF stop the core. `halted` goes high 5 cycles after the stop instruction's fetch begins and stays high. `mem_addr` then holds the stop instruction's address, and `mem_we` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 8 | Memory address |
| mem_rdata | input | 8 | Read data, valid one cycle after its address |
| mem_wdata | output | 8 | Write data (the accumulator) |
| mem_we | output | 1 | Write enable |
| halted | output | 1 | High once the stop instruction has executed |

## Verification
The bench builds the core at its package defaults: an 8-bit datapath and an 8-bit address. Programs therefore sit at low addresses and operands above 0x80, and every shift amount from 0 to 7 is reachable. One template program per table row observes each operation's result through a store and its flags through a chain of conditional jumps. Directed programs time the five-cycle cadence, run a backward-branch loop, and compose OR and subtraction.

// File: rtl/acc8_pkg.sv
package acc8_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = DATA_W;
    localparam int OP_W    = 3;
    localparam int CTL_W   = DATA_W - OP_W;
    localparam int SHAMT_W = $clog2(DATA_W);

    // control-bit masks inside byte 0
    localparam logic [CTL_W-1:0] M_LEFT   = CTL_W'(5'b10000);
    localparam logic [CTL_W-1:0] M_ARITH  = CTL_W'(5'b01000);
    localparam logic [CTL_W-1:0] M_BACK   = CTL_W'(5'b01000);
    localparam logic [CTL_W-1:0] M_ON_N   = CTL_W'(5'b00100);
    localparam logic [CTL_W-1:0] M_ON_P   = CTL_W'(5'b00010);
    localparam logic [CTL_W-1:0] M_ALWAYS = CTL_W'(5'b00001);

    typedef enum logic [OP_W-1:0] {
        OP_AND, OP_NOT, OP_ADD, OP_SHFT, OP_LD, OP_ST, OP_CMP, OP_JMP
    } opcode_e;

    typedef enum logic [2:0] {
        PH_F0, PH_F1, PH_DEC, PH_OPR, PH_EXE, PH_HALT
    } phase_e;

    typedef struct packed {
        opcode_e            op;
        logic [CTL_W-1:0]   ctl;
        logic [DATA_W-1:0]  arg;
    } instr_t;

    typedef struct packed {
        logic neg;
        logic pos;
    } flags_t;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        flags_t            fl;
        logic              wr_acc;
        logic              wr_flags;
    } alu_res_t;

    function automatic flags_t sign_flags(input logic [DATA_W-1:0] v);
        flags_t f;
        f.neg = v[DATA_W-1];
        f.pos = !v[DATA_W-1] && (v != '0);
        return f;
    endfunction
endpackage

// File: rtl/acc8_shifter.sv
module acc8_shifter #(
    parameter int W = 8,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    input  logic          left,
    input  logic          arith,
    output logic [W-1:0]  dout
);
    always_comb begin
        if (left)
            dout = din << amt;
        else if (arith)
            dout = W'($signed(din) >>> amt);
        else
            dout = din >> amt;
    end
endmodule

// File: rtl/acc8_alu.sv
module acc8_alu
    import acc8_pkg::*;
(
    input  opcode_e            op,
    input  logic [CTL_W-1:0]   ctl,
    input  logic [DATA_W-1:0]  imm,
    input  logic [DATA_W-1:0]  acc,
    input  logic [DATA_W-1:0]  opnd,
    output alu_res_t           res
);
    logic [DATA_W-1:0]  shifted;
    logic [SHAMT_W-1:0] shamt;
    logic               sh_left, sh_arith;

    assign shamt    = SHAMT_W'(imm % DATA_W);
    assign sh_left  = (ctl & M_LEFT) != '0;
    assign sh_arith = (ctl & M_ARITH) != '0;

    acc8_shifter #(.W(DATA_W)) u_shift (
        .din(acc), .amt(shamt), .left(sh_left), .arith(sh_arith), .dout(shifted)
    );

    always_comb begin
        res.value    = acc;
        res.wr_acc   = 1'b1;
        res.wr_flags = 1'b1;
        unique case (op)
            OP_AND:  res.value = acc & opnd;
            OP_NOT:  res.value = ~acc;
            OP_ADD:  res.value = acc + opnd;
            OP_SHFT: res.value = shifted;
            OP_LD:   res.value = opnd;
            OP_CMP:  res.wr_acc = 1'b0;
            OP_ST, OP_JMP: begin
                res.wr_acc   = 1'b0;
                res.wr_flags = 1'b0;
            end
        endcase
        if (op == OP_CMP) begin
            res.fl.pos = $signed(acc) > $signed(opnd);
            res.fl.neg = $signed(acc) < $signed(opnd);
        end else begin
            res.fl = sign_flags(res.value);
        end
    end
endmodule

// File: rtl/acc8_ctrl.sv
module acc8_ctrl
    import acc8_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  flags_t             flags,
    output phase_e             phase,
    output instr_t             ir,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_we,
    output logic               exec_en,
    output logic               halted
);
    logic [ADDR_W-1:0] pc, seq_pc, step, next_pc;
    logic              is_stop, taken;

    assign is_stop = &ir;
    assign taken   = (ir.op == OP_JMP) &&
                     (((ir.ctl & M_ALWAYS) != '0) ||
                      (((ir.ctl & M_ON_N) != '0) && flags.neg) ||
                      (((ir.ctl & M_ON_P) != '0) && flags.pos));
    assign seq_pc  = pc + ADDR_W'(2);
    assign step    = {ir.arg[ADDR_W-2:0], 1'b0};
    assign next_pc = !taken ? seq_pc :
                     ((ir.ctl & M_BACK) != '0) ? seq_pc - step : seq_pc + step;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_F0;
            pc    <= '0;
            ir    <= '0;
        end else begin
            unique case (phase)
                PH_F0:  phase <= PH_F1;
                PH_F1: begin
                    ir.op  <= opcode_e'(mem_rdata[DATA_W-1 -: OP_W]);
                    ir.ctl <= mem_rdata[CTL_W-1:0];
                    phase  <= PH_DEC;
                end
                PH_DEC: begin
                    ir.arg <= mem_rdata;
                    phase  <= PH_OPR;
                end
                PH_OPR: phase <= PH_EXE;
                PH_EXE: begin
                    if (is_stop) begin
                        phase <= PH_HALT;
                    end else begin
                        pc    <= next_pc;
                        phase <= PH_F0;
                    end
                end
                default: phase <= PH_HALT;
            endcase
        end
    end

    always_comb begin
        unique case (phase)
            PH_F1:          mem_addr = pc + ADDR_W'(1);
            PH_OPR, PH_EXE: mem_addr = ir.arg;
            default:        mem_addr = pc;
        endcase
    end

    assign mem_we  = (phase == PH_OPR) && (ir.op == OP_ST);
    assign exec_en = (phase == PH_EXE);
    assign halted  = (phase == PH_HALT);
endmodule

// File: rtl/acc8_core.sv
module acc8_core
    import acc8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              halted
);
    phase_e            phase;
    instr_t            ir;
    flags_t            flags;
    logic [DATA_W-1:0] acc;
    logic              exec_en;
    alu_res_t          res;

    acc8_ctrl u_ctrl (
        .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .flags(flags),
        .phase(phase), .ir(ir), .mem_addr(mem_addr), .mem_we(mem_we),
        .exec_en(exec_en), .halted(halted)
    );

    acc8_alu u_alu (
        .op(ir.op), .ctl(ir.ctl), .imm(ir.arg), .acc(acc),
        .opnd(mem_rdata), .res(res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            flags <= '0;
        end else if (exec_en) begin
            if (res.wr_acc)   acc   <= res.value;
            if (res.wr_flags) flags <= res.fl;
        end
    end

    assign mem_wdata = acc;
endmodule

// File: rtl/acc8_core_chk.sv
module acc8_core_chk
    import acc8_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              halted,
    input phase_e            phase
);
    a_r1_start_at_zero: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mem_addr == '0 && phase == PH_F0 && !halted));

    a_r2_second_byte_next: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_F1) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

    a_r2_fetch_even: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_F0) |-> !mem_addr[0]);

    a_r5_write_one_cycle: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    a_r5_write_in_operand_phase: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (phase == PH_OPR));

    a_r11_stays_halted: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    a_r11_address_frozen: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(mem_addr));

    a_r11_no_write_halted: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_we);
endmodule

bind acc8_core acc8_core_chk u_chk (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
    .halted(halted), .phase(phase)
);

// File: tb/acc8_core_bench.sv
module acc8_core_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] FZ = 2'd0, FN = 2'd1, FP = 2'd2;

    typedef struct packed {
        logic [7:0] op_byte;
        logic [7:0] a;
        logic [7:0] b;
        logic [7:0] res;
        logic [1:0] fl;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 8'hF0, 8'h3C, 8'h30, FP},  // R3 AND
        '{8'h00, 8'h0F, 8'hF0, 8'h00, FZ},  // R3 AND to zero
        '{8'h20, 8'h55, 8'h00, 8'hAA, FN},  // R3 NOT
        '{8'h20, 8'hFF, 8'h00, 8'h00, FZ},  // R3 NOT to zero
        '{8'h40, 8'h7F, 8'h01, 8'h80, FN},  // R4 ADD sign change
        '{8'h40, 8'hFF, 8'h01, 8'h00, FZ},  // R4 ADD wraps
        '{8'h40, 8'h10, 8'h22, 8'h32, FP},  // R4 ADD
        '{8'h70, 8'h81, 8'h01, 8'h02, FP},  // R6 left logical
        '{8'h60, 8'h80, 8'h03, 8'h10, FP},  // R6 right logical
        '{8'h68, 8'h80, 8'h03, 8'hF0, FN},  // R6 right arithmetic
        '{8'h68, 8'h40, 8'h02, 8'h10, FP},  // R6 right arithmetic positive
        '{8'h60, 8'h02, 8'hF9, 8'h01, FP},  // R6 upper amount bits ignored
        '{8'h78, 8'hC1, 8'h01, 8'h82, FN},  // R6 left arithmetic zero fill
        '{8'h80, 8'h12, 8'h85, 8'h85, FN},  // R4 LD
        '{8'hC0, 8'h05, 8'h03, 8'h05, FP},  // R8 CMP greater
        '{8'hC0, 8'hFE, 8'h01, 8'hFE, FN},  // R8 CMP signed smaller
        '{8'hC0, 8'h33, 8'h33, 8'h33, FZ}   // R8 CMP equal
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] mem_addr, mem_rdata, mem_wdata;
    logic       mem_we, halted;
    logic       load_img = 1'b0;
    logic [7:0] img [256];
    logic [7:0] mem [256];
    int         n_checks = 0;
    int         n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (load_img) begin
            for (int i = 0; i < 256; i++) mem[i] <= img[i];
        end else if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
        end
        mem_rdata <= mem[mem_addr];
    end

    acc8_core u_acc8_core (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .halted(halted)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_img();
        for (int i = 0; i < 256; i++) img[i] = 8'h00;
    endtask

    task automatic put(input int at, input logic [7:0] b0, input logic [7:0] b1);
        img[at]   = b0;
        img[at+1] = b1;
    endtask

    task automatic run_image(output int cycles);
        @(negedge clk);
        rst = 1'b1;
        load_img = 1'b1;
        @(negedge clk);
        load_img = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        cycles = 0;
        while (!halted && cycles < 2000) begin
            @(posedge clk);
            #1;
            cycles++;
        end
    endtask

    function automatic logic [7:0] marker(input logic [1:0] f);
        return (f == FN) ? 8'hE1 : (f == FP) ? 8'h7C : 8'h5A;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        int cyc;
        logic [7:0] hold_addr;

        // R1: reset state
        clear_img();
        put(0, 8'hFF, 8'hFF);
        @(negedge clk);
        load_img = 1'b1;
        repeat (2) @(negedge clk);
        load_img = 1'b0;
        rst = 1'b0;
        #1;
        check("R1 mem_addr after reset", mem_addr, 8'h00);
        check("R1 mem_we after reset", {7'd0, mem_we}, 8'h00);
        check("R1 halted after reset", {7'd0, halted}, 8'h00);

        // table walk: op result via store, flags via conditional jumps (R7, R9, R10)
        for (int v = 0; v < NV; v++) begin
            clear_img();
            put(0,  8'h80, 8'h80);
            put(2,  VECS[v].op_byte,
                (VECS[v].op_byte[7:5] == 3'd3) ? VECS[v].b : 8'h81);
            put(4,  8'hA0, 8'h90);
            put(6,  8'hE4, 8'h03);
            put(8,  8'hE2, 8'h05);
            put(10, 8'h80, 8'hA0);
            put(12, 8'hE1, 8'h05);
            put(14, 8'h80, 8'hA1);
            put(16, 8'hE1, 8'h03);
            put(18, 8'hE0, 8'h00);
            put(20, 8'h80, 8'hA2);
            put(22, 8'hE1, 8'h00);
            put(24, 8'hA0, 8'h91);
            put(26, 8'hFF, 8'hFF);
            img[8'h80] = VECS[v].a;
            img[8'h81] = VECS[v].b;
            img[8'hA0] = 8'h5A;
            img[8'hA1] = 8'hE1;
            img[8'hA2] = 8'h7C;
            run_image(cyc);
            check($sformatf("R3/R4/R6/R8 result vec %0d", v), mem[8'h90], VECS[v].res);
            check($sformatf("R7/R8/R9 flags vec %0d", v), mem[8'h91], marker(VECS[v].fl));
            if (v == 0) begin
                check("R5 source byte untouched", mem[8'h81], VECS[v].b);
                check("R11 halted high", {7'd0, halted}, 8'h01);
                hold_addr = mem_addr;
                check("R11 stop address", hold_addr, 8'h1A);
                repeat (5) @(posedge clk);
                #1;
                check("R11 address frozen", mem_addr, hold_addr);
                check("R11 no write halted", {7'd0, mem_we}, 8'h00);
                check("R11 still halted", {7'd0, halted}, 8'h01);
            end
        end

        // R2 / R10: two no-operation jumps then stop, 15 cycles
        clear_img();
        put(0, 8'hE1, 8'h00);
        put(2, 8'hE0, 8'h00);
        put(4, 8'hFF, 8'hFF);
        run_image(cyc);
        check("R2 R10 cycles to halt", 8'(cyc), 8'd15);

        // R9: backward conditional loop, 3 iterations, 14 instructions
        clear_img();
        put(0,  8'h80, 8'h84);
        put(2,  8'h40, 8'h85);
        put(4,  8'hA0, 8'h84);
        put(6,  8'hEA, 8'h04);
        put(8,  8'hA0, 8'h92);
        put(10, 8'hFF, 8'hFF);
        img[8'h84] = 8'h03;
        img[8'h85] = 8'hFF;
        img[8'h92] = 8'h77;
        run_image(cyc);
        check("R9 loop counter", mem[8'h84], 8'h00);
        check("R9 loop cycles", 8'(cyc), 8'd70);
        check("R5 store after loop", mem[8'h92], 8'h00);

        // R3: OR from NOT/AND
        clear_img();
        put(0,  8'h80, 8'h80);
        put(2,  8'h20, 8'h00);
        put(4,  8'hA0, 8'h82);
        put(6,  8'h80, 8'h81);
        put(8,  8'h20, 8'h00);
        put(10, 8'h00, 8'h82);
        put(12, 8'h20, 8'h00);
        put(14, 8'hA0, 8'h90);
        put(16, 8'hFF, 8'hFF);
        img[8'h80] = 8'h0C;
        img[8'h81] = 8'h21;
        run_image(cyc);
        check("R3 composed OR", mem[8'h90], 8'h2D);

        // R4: subtraction from NOT/ADD
        clear_img();
        put(0,  8'h80, 8'h81);
        put(2,  8'h20, 8'h00);
        put(4,  8'h40, 8'h83);
        put(6,  8'hA0, 8'h82);
        put(8,  8'h80, 8'h80);
        put(10, 8'h40, 8'h82);
        put(12, 8'hA0, 8'h91);
        put(14, 8'hFF, 8'hFF);
        img[8'h80] = 8'h50;
        img[8'h81] = 8'h13;
        img[8'h83] = 8'h01;
        run_image(cyc);
        check("R4 negated operand", mem[8'h82], 8'hED);
        check("R4 composed subtract", mem[8'h91], 8'h3D);

        // R1: reset clears a halted core
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset clears halt", {7'd0, halted}, 8'h00);
        rst = 1'b0;

        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule